// File: doc/BRIEF.md
# DMA End-of-Transfer Controller

This block runs one DMA transfer between a local data bus and a bulk endpoint FIFO of a USB device, and decides when that transfer ends. Setting the enable input starts a transfer. The block loads an internal byte counter from the programmed length and raises its DMA request. Each qualified acknowledge cycle then produces one FIFO data strobe and lowers the counter. In acknowledge-only mode the acknowledge alone qualifies the cycle. In strobe mode the read or write strobe must come with the acknowledge. A configuration bit selects a 16-bit bus, and the counter then drops by two for each word.

Four events end a transfer: an external end-of-transfer pulse, the counter reaching zero, a short packet on an OUT endpoint, and software clearing the enable. The counter and short-packet events each count only when their own configuration bit allows them. When two events fall in one cycle, a fixed priority picks the one that is recorded. An external end-of-transfer also acts on the FIFO. On an OUT endpoint the block issues a flush of the active buffer. On an IN endpoint it issues a commit, so the partly filled packet goes out on the next IN token. When a transfer ends, the block records a sticky status flag and a cause code, and software clears them by writing one.

Top module: `dma_eot_ctrl`

## Requirements
- R1: After reset, dreq, fifo_stb, fifo_flush, pkt_commit and eot_status are 0 and eot_cause is 0.
- R2: A 0-to-1 change of dma_en while no transfer is running loads xfer_len into the counter, and dreq is 1 from the next clock edge. dreq stays 1 until a stop condition ends the transfer.
- R3: With cfg_mode bit 2 = 1 (acknowledge-only), fifo_stb = dreq & dack, and rd_stb and wr_stb have no effect. With bit 2 = 0, fifo_stb = dreq & dack & (rd_stb | wr_stb).
- R4: Each fifo_stb lowers the counter by 1, or by 2 when cfg_mode bit 3 = 1, and the counter saturates at 0. With cfg_mode bit 0 = 1, the transfer ends in the cycle in which the counter value after that cycle's strobe is 0. This includes a loaded length of 0, which ends the transfer in its first active cycle.
- R5: With cfg_mode bit 0 = 0, the counter reaching zero does not end the transfer.
- R6: short_pkt ends the transfer only when ep_in = 0 (OUT endpoint) and cfg_mode bit 1 = 1. In all other cases it is ignored.
- R7: An ext_eot pulse during a transfer ends it. In the next cycle there is a one-cycle pulse: fifo_flush if ep_in = 0, or pkt_commit if ep_in = 1. No other stop cause produces either pulse.
- R8: dma_en = 0 during a transfer ends it.
- R9: dreq is 0 one clock after the stop cycle, and eot_status becomes 1 and stays 1. eot_clr = 1 clears eot_status and eot_cause, unless a stop occurs in the same cycle, in which case the stop wins.
- R10: eot_cause records the stop cause: 1 for external EOT, 2 for counter, 3 for short packet, 4 for software disable. If several causes occur in one cycle, the code of the highest-priority cause is recorded, in the order 1, 2, 3, 4.
- R11: After a transfer ends, a new transfer starts only after dma_en has been 0 for at least one cycle and then 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | DMA enable bit |
| cfg_mode | input | 4 | Bit 0 counter stop, bit 1 short-packet stop, bit 2 acknowledge-only mode, bit 3 16-bit bus |
| xfer_len | input | CNT_W | Programmed byte count |
| ext_eot | input | 1 | External end-of-transfer pulse |
| dack | input | 1 | DMA acknowledge |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| ep_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| short_pkt | input | 1 | Short packet received |
| eot_clr | input | 1 | Write-one-to-clear for status and cause |
| dreq | output | 1 | DMA request |
| fifo_stb | output | 1 | FIFO data strobe |
| fifo_flush | output | 1 | Flush active OUT buffer |
| pkt_commit | output | 1 | Mark IN packet ready |
| eot_status | output | 1 | Sticky end-of-transfer flag |
| eot_cause | output | 3 | Stop cause code |

## Verification
The bench builds the block with CNT_W = 8 instead of the default 16. Loaded lengths stay small, so transfers in the random phase often run the counter down to zero. This brings counter stops, saturation after an odd count on the 16-bit bus, and collisions of the counter with other stop causes within a few thousand cycles. The narrow width changes no behaviour, because the counter logic is the same at every width.

// File: rtl/dma_eot_pkg.sv
package dma_eot_pkg;

    localparam int CFG_W      = 4;
    localparam int CFG_CNTSTP = 0;
    localparam int CFG_SHTSTP = 1;
    localparam int CFG_ACKONL = 2;
    localparam int CFG_WIDE   = 3;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_EXT   = 3'd1,
        CAUSE_CNT   = 3'd2,
        CAUSE_SHORT = 3'd3,
        CAUSE_SWOFF = 3'd4
    } eot_cause_e;

    localparam int NUM_CAUSES = 4;

    typedef struct packed {
        logic       active;
        logic       en_prev;
        logic       eot;
        eot_cause_e cause;
        logic       flush;
        logic       commit;
    } ctrl_state_t;

endpackage

// File: rtl/dma_strobe_decode.sv
module dma_strobe_decode (
    input  logic active,
    input  logic ack_only,
    input  logic dack,
    input  logic rd_stb,
    input  logic wr_stb,
    output logic xfer
);
    logic qual;

    always_comb begin
        if (ack_only) qual = dack;
        else          qual = dack & (rd_stb | wr_stb);
        xfer = active & qual;
    end
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             wide,
    output logic             rem_zero
);
    localparam logic [CNT_W-1:0] STEP_NARROW = CNT_W'(1);
    localparam logic [CNT_W-1:0] STEP_WIDE   = CNT_W'(2);

    logic [CNT_W-1:0] cnt_d, cnt_q, rem, step;

    always_comb begin
        step = wide ? STEP_WIDE : STEP_NARROW;
        rem  = cnt_q;
        if (dec) rem = (cnt_q > step) ? (cnt_q - step) : '0;
        rem_zero = (rem == '0);
        cnt_d = load ? load_val : rem;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_stop_arbiter.sv
module dma_stop_arbiter
    import dma_eot_pkg::*;
(
    input  logic       active,
    input  logic       ext_req,
    input  logic       cnt_req,
    input  logic       short_req,
    input  logic       swoff_req,
    output logic       stop,
    output eot_cause_e cause
);
    logic [NUM_CAUSES-1:0] reqs;

    always_comb begin
        reqs  = {swoff_req, short_req, cnt_req, ext_req};
        cause = CAUSE_NONE;
        for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
            if (active && reqs[i]) cause = eot_cause_e'(i + 1);
        end
        stop = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/dma_eot_ctrl.sv
module dma_eot_ctrl
    import dma_eot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic [3:0]       cfg_mode,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             ext_eot,
    input  logic             dack,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             ep_in,
    input  logic             short_pkt,
    input  logic             eot_clr,
    output logic             dreq,
    output logic             fifo_stb,
    output logic             fifo_flush,
    output logic             pkt_commit,
    output logic             eot_status,
    output logic [2:0]       eot_cause
);
    ctrl_state_t st_d, st_q;
    logic        start, xfer, rem_zero, stop;
    eot_cause_e  stop_cause;

    dma_strobe_decode u_decode (
        .active   (st_q.active),
        .ack_only (cfg_mode[CFG_ACKONL]),
        .dack     (dack),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .xfer     (xfer)
    );

    dma_byte_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (xfer_len),
        .dec      (xfer),
        .wide     (cfg_mode[CFG_WIDE]),
        .rem_zero (rem_zero)
    );

    dma_stop_arbiter u_arb (
        .active    (st_q.active),
        .ext_req   (ext_eot),
        .cnt_req   (cfg_mode[CFG_CNTSTP] & rem_zero),
        .short_req (short_pkt & ~ep_in & cfg_mode[CFG_SHTSTP]),
        .swoff_req (~dma_en),
        .stop      (stop),
        .cause     (stop_cause)
    );

    always_comb begin
        start        = dma_en & ~st_q.en_prev & ~st_q.active;
        st_d         = st_q;
        st_d.en_prev = dma_en;
        st_d.flush   = 1'b0;
        st_d.commit  = 1'b0;
        if (start) st_d.active = 1'b1;
        if (eot_clr) begin
            st_d.eot   = 1'b0;
            st_d.cause = CAUSE_NONE;
        end
        if (stop) begin
            st_d.active = 1'b0;
            st_d.eot    = 1'b1;
            st_d.cause  = stop_cause;
            st_d.flush  = (stop_cause == CAUSE_EXT) & ~ep_in;
            st_d.commit = (stop_cause == CAUSE_EXT) &  ep_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dreq       = st_q.active;
    assign fifo_stb   = xfer;
    assign fifo_flush = st_q.flush;
    assign pkt_commit = st_q.commit;
    assign eot_status = st_q.eot;
    assign eot_cause  = st_q.cause;

    assert_dreq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && stop) |=> (!dreq && eot_status));

    assert_fifo_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_flush || pkt_commit) |-> ($fell(dreq) && !(fifo_flush && pkt_commit)));

    assert_start_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq) |-> $past(dma_en));

    assert_strobe_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_stb |-> (dreq && dack));

    assert_cause_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_cause != 3'd0) |-> eot_status);
endmodule

// File: tb/dma_eot_ctrl_bench.sv
module dma_eot_ctrl_bench;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_en = 0, ext_eot = 0, dack = 0, rd_stb = 0, wr_stb = 0;
    logic ep_in = 0, short_pkt = 0, eot_clr = 0;
    logic [3:0] cfg_mode = 0;
    logic [CNT_W-1:0] xfer_len = 0;
    logic dreq, fifo_stb, fifo_flush, pkt_commit, eot_status;
    logic [2:0] eot_cause;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_eot_ctrl #(.CNT_W(CNT_W)) u_dma_eot_ctrl (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .cfg_mode(cfg_mode),
        .xfer_len(xfer_len), .ext_eot(ext_eot), .dack(dack), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .ep_in(ep_in), .short_pkt(short_pkt), .eot_clr(eot_clr),
        .dreq(dreq), .fifo_stb(fifo_stb), .fifo_flush(fifo_flush),
        .pkt_commit(pkt_commit), .eot_status(eot_status), .eot_cause(eot_cause)
    );

    // behavioural reference
    bit m_active, m_enp, m_eot, m_flush, m_commit;
    int m_cnt, m_cause;

    function automatic bit m_strobe();
        bit q = cfg_mode[2] ? dack : (dack && (rd_stb || wr_stb));
        return m_active && q;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_enp = 0; m_eot = 0; m_flush = 0; m_commit = 0;
            m_cnt = 0; m_cause = 0;
        end else begin
            int step, rem, c;
            step = cfg_mode[3] ? 2 : 1;
            rem = m_strobe() ? ((m_cnt > step) ? m_cnt - step : 0) : m_cnt;
            c = 0;
            m_flush = 0; m_commit = 0;
            if (eot_clr) begin m_eot = 0; m_cause = 0; end
            if (m_active) begin
                if (ext_eot) c = 1;
                else if (cfg_mode[0] && rem == 0) c = 2;
                else if (short_pkt && !ep_in && cfg_mode[1]) c = 3;
                else if (!dma_en) c = 4;
                m_cnt = rem;
                if (c != 0) begin
                    m_active = 0; m_eot = 1; m_cause = c;
                    m_flush = (c == 1) && !ep_in;
                    m_commit = (c == 1) && ep_in;
                end
            end else if (dma_en && !m_enp) begin
                m_active = 1; m_cnt = int'(xfer_len);
            end
            m_enp = dma_en;
        end
    end

    task automatic cmp(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        #1;
        cmp("R3 fifo_stb", int'(fifo_stb), int'(m_strobe()));
        @(posedge clk);
        #1;
        cmp("R2/R9 dreq", int'(dreq), int'(m_active));
        cmp("R9 eot_status", int'(eot_status), int'(m_eot));
        cmp("R10 eot_cause", int'(eot_cause), m_cause);
        cmp("R7 fifo_flush", int'(fifo_flush), int'(m_flush));
        cmp("R7 pkt_commit", int'(pkt_commit), int'(m_commit));
    endtask

    task automatic quiet();
        ext_eot = 0; dack = 0; rd_stb = 0; wr_stb = 0; short_pkt = 0; eot_clr = 0;
    endtask

    task automatic go(int len, logic [3:0] cfg, logic dir_in);
        quiet();
        dma_en = 0; cyc();
        cfg_mode = cfg; xfer_len = CNT_W'(len); ep_in = dir_in; dma_en = 1; cyc();
        cmp("R2 dreq after enable", int'(dreq), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cmp("R1 dreq", int'(dreq), 0);
        cmp("R1 eot_status", int'(eot_status), 0);
        cmp("R1 eot_cause", int'(eot_cause), 0);
        cmp("R1 flush/commit", int'(fifo_flush | pkt_commit), 0);
        rst_n = 1;
        cyc();

        // R4 counter stop, ack-only, rd/wr toggling ignored (R3)
        go(5, 4'b0101, 0);
        for (int i = 0; i < 5; i++) begin
            dack = 1; rd_stb = i[0]; wr_stb = 0; cyc();
            if (i == 3) cmp("R4 dreq before count end", int'(dreq), 1);
        end
        cmp("R4 counter end", int'(eot_cause), 2);
        // R11 no restart while enable held
        quiet();
        for (int i = 0; i < 4; i++) cyc();
        cmp("R11 no restart", int'(dreq), 0);
        eot_clr = 1; cyc(); eot_clr = 0;
        cmp("R9 clear status", int'(eot_status), 0);

        // R4 wide bus: 5 -> 3 -> 1 -> 0
        go(5, 4'b1101, 0);
        dack = 1; cyc(); cyc();
        cmp("R4 wide still running", int'(dreq), 1);
        cyc();
        cmp("R4 wide end", int'(eot_cause), 2);

        // R3 strobe mode: ack alone moves nothing
        go(3, 4'b0001, 0);
        dack = 1;
        for (int i = 0; i < 4; i++) cyc();
        cmp("R3 ack without strobe", int'(dreq), 1);
        rd_stb = 1; cyc(); cyc(); rd_stb = 0; wr_stb = 1; cyc();
        cmp("R3 strobes end count", int'(eot_cause), 2);

        // R5 counter stop disabled, then R8 software disable
        go(2, 4'b0100, 0);
        dack = 1;
        for (int i = 0; i < 5; i++) cyc();
        cmp("R5 no counter stop", int'(dreq), 1);
        dack = 0; dma_en = 0; cyc();
        cmp("R8 disable cause", int'(eot_cause), 4);
        cmp("R8 no fifo action", int'(fifo_flush | pkt_commit), 0);

        // R6 short packet
        go(10, 4'b0110, 1);
        short_pkt = 1; cyc(); short_pkt = 0;
        cmp("R6 short on IN ignored", int'(dreq), 1);
        ep_in = 0; cfg_mode = 4'b0100; short_pkt = 1; cyc(); short_pkt = 0;
        cmp("R6 short without enable ignored", int'(dreq), 1);
        cfg_mode = 4'b0110; short_pkt = 1; cyc(); short_pkt = 0;
        cmp("R6 short on OUT", int'(eot_cause), 3);

        // R7 external EOT
        go(10, 4'b0100, 0);
        ext_eot = 1; cyc(); ext_eot = 0;
        cmp("R7 OUT flush", int'(fifo_flush), 1);
        cmp("R7 OUT cause", int'(eot_cause), 1);
        cyc();
        cmp("R7 flush one cycle", int'(fifo_flush), 0);
        go(10, 4'b0100, 1);
        ext_eot = 1; cyc(); ext_eot = 0;
        cmp("R7 IN commit", int'(pkt_commit), 1);
        cmp("R7 IN no flush", int'(fifo_flush), 0);

        // R10 priority
        go(1, 4'b0111, 0);
        dack = 1; ext_eot = 1; short_pkt = 1; dma_en = 0; cyc();
        cmp("R10 ext wins", int'(eot_cause), 1);
        go(1, 4'b0111, 0);
        dack = 1; short_pkt = 1; dma_en = 0; cyc();
        cmp("R10 counter over short", int'(eot_cause), 2);
        go(9, 4'b0111, 0);
        short_pkt = 1; dma_en = 0; eot_clr = 1; cyc();
        cmp("R10 short over disable", int'(eot_cause), 3);
        cmp("R9 stop beats clear", int'(eot_status), 1);

        // R4 zero length
        go(0, 4'b0101, 0);
        cyc();
        cmp("R4 zero length end", int'(eot_cause), 2);

        // random phase
        quiet();
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) dma_en = ~dma_en;
            if (!dreq) begin
                xfer_len = CNT_W'($urandom_range(0, 12));
                cfg_mode = 4'($urandom);
                ep_in = 1'($urandom);
            end
            dack = ($urandom_range(0, 2) != 0);
            rd_stb = 1'($urandom); wr_stb = 1'($urandom);
            ext_eot = ($urandom_range(0, 39) == 0);
            short_pkt = ($urandom_range(0, 29) == 0);
            eot_clr = ($urandom_range(0, 19) == 0);
            cyc();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end
endmodule